// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block keeps the pending state of inter-processor interrupts for a small cluster of processors. A processor raises an interrupt by writing a dispatch word that names an interrupt number, a list of target processors and a filter mode. For every processor the dispatch reaches, the block marks that interrupt pending and records which processor sent it. Each (target, interrupt) pair therefore holds a source mask with one bit per possible sender.

A second access port gives software two windows onto those masks, one that sets bits and one that clears bits. Each window has one byte per interrupt number and allows byte or aligned word accesses. Both windows act on, and read back, the masks of the processor that makes the access. A pending flag for every (target, interrupt) pair is driven out as a flat vector for the downstream logic that prioritises and delivers interrupts.

Top module: `sgi_dispatch`

## Requirements
- R1: A dispatch write takes the interrupt number from bits [3:0], the target list from bits [23:16] (bit k names processor k) and the filter mode from bits [25:24]. Mode 0 sends the interrupt to exactly the processors named in the list.
- R2: Mode 1 sends the interrupt to every online processor except the one that makes the write.
- R3: Mode 2 sends the interrupt only to the processor that makes the write.
- R4: Mode 3 is reserved, and a dispatch write in that mode changes no state.
- R5: For each processor the dispatch reaches, the interrupt becomes pending there and the sender's bit (bit number equal to the sender's ID) is set in that interrupt's source mask.
- R6: A processor whose ID is equal to or greater than `online_cnt` is never reached by a dispatch, even if the target list names it.
- R7: A write to the clear window (`win_clear`=1) removes the written bits from the addressed source masks of the accessing processor. Pending drops when a mask becomes zero.
- R8: A write to the set window (`win_clear`=0) ORs the written bits into the addressed masks. Pending is raised only if the resulting mask is nonzero, so writing zero to an empty mask leaves it not pending.
- R9: A window read returns the accessing processor's masks. A byte access returns the mask of interrupt `win_idx` in bits [7:0], with bits [31:8] zero. A word access returns the masks of four interrupts: the base is `win_idx` with its two low bits cleared, and byte lane k holds interrupt base+k. Writes use the same lane mapping.
- R10: When a dispatch and a window write happen in the same cycle, the dispatch is applied first and the window write is applied to its result.
- R11: After reset every source mask is zero and no interrupt is pending. Output bit `pend_o[c*16+i]` is the pending flag of interrupt i at processor c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| online_cnt | input | 4 | Number of online processors (1 to 8) |
| disp_valid | input | 1 | Dispatch write strobe |
| disp_cpu | input | 3 | ID of the processor making the dispatch |
| disp_data | input | 32 | Dispatch word |
| win_valid | input | 1 | Window access strobe |
| win_write | input | 1 | 1 = write, 0 = read |
| win_clear | input | 1 | 1 = clear window, 0 = set window |
| win_word | input | 1 | 1 = aligned word access, 0 = byte access |
| win_cpu | input | 3 | ID of the processor making the window access |
| win_idx | input | 4 | Interrupt number (byte address within the window) |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data, valid in the same cycle |
| pend_o | output | 128 | Pending flag per processor and interrupt |

## Verification
The assertions assume that the requester IDs on both ports are below `online_cnt` and that `online_cnt` stays between 1 and the processor count. They also assume that `online_cnt` does not change in a cycle that carries a dispatch, because the offline checks compare against its current value. The stimulus sets `online_cnt` only while both ports are idle, uses only online requesters, and uses word accesses only on indices that are a multiple of four. Under those limits, each pending flag equals the OR of its source mask in every cycle, and the assertions rely on that.

// File: rtl/sgi_pkg.sv
// Package: shared sizes, dispatch-word field positions and filter modes for
// the software-generated interrupt dispatcher.
package sgi_pkg;
    localparam int SGI_CPUS     = 8;   // processors, and bits per source mask
    localparam int SGI_INTS     = 16;  // interrupt numbers
    localparam int LANE_W       = 8;   // bits per window byte
    localparam int LANES        = 4;   // bytes per window word
    localparam int F_INT_LO     = 0;   // dispatch word: interrupt number
    localparam int F_LIST_LO    = 16;  // dispatch word: target list
    localparam int F_MODE_LO    = 24;  // dispatch word: filter mode

    typedef enum logic [1:0] {
        FILT_LIST   = 2'd0,
        FILT_OTHERS = 2'd1,
        FILT_SELF   = 2'd2,
        FILT_RSVD   = 2'd3
    } filt_mode_e;
endpackage

// File: rtl/sgi_target_decode.sv
// Turns a dispatch word and the requester ID into a target vector.
// Assumes: req_cpu < NUM_CPU; online_cnt <= NUM_CPU.
module sgi_target_decode #(
    parameter int NUM_CPU = sgi_pkg::SGI_CPUS,
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input  sgi_pkg::filt_mode_e     mode,
    input  logic [7:0]              list,
    input  logic [CPU_W-1:0]        req_cpu,
    input  logic [CPU_W:0]          online_cnt,
    output logic [NUM_CPU-1:0]      targets
);
    logic [NUM_CPU-1:0] online_mask;
    logic [NUM_CPU-1:0] self_bit;

    // Online processors are those with ID below the online count.
    genvar c;
    generate
        for (c = 0; c < NUM_CPU; c++) begin : g_online
            assign online_mask[c] = (CPU_W'(c) < online_cnt[CPU_W-1:0]) || online_cnt[CPU_W];
            assign self_bit[c]    = (req_cpu == CPU_W'(c));
        end
    endgenerate

    // Select the filter, then drop anything offline.
    always_comb begin
        unique case (mode)
            sgi_pkg::FILT_LIST:   targets = list[NUM_CPU-1:0] & online_mask;
            sgi_pkg::FILT_OTHERS: targets = online_mask & ~self_bit;
            sgi_pkg::FILT_SELF:   targets = self_bit & online_mask;
            default:              targets = '0;
        endcase
    end
endmodule

// File: rtl/sgi_window_lanes.sv
// Maps a byte or aligned-word window access to per-interrupt lanes, and
// builds read data from the accessing processor's source masks.
// Assumes: word accesses use an index whose two low bits are ignored.
module sgi_window_lanes #(
    parameter int NUM_CPU = sgi_pkg::SGI_CPUS,
    parameter int NUM_INT = sgi_pkg::SGI_INTS,
    localparam int INT_W  = $clog2(NUM_INT),
    localparam int LW     = sgi_pkg::LANE_W,
    localparam int NL     = sgi_pkg::LANES
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              win_valid,
    input  logic                              win_word,
    input  logic [INT_W-1:0]                  win_idx,
    input  logic [NL*LW-1:0]                  win_wdata,
    input  logic [NUM_INT-1:0][NUM_CPU-1:0]   rd_masks,
    output logic [NUM_INT-1:0]                lane_hit,
    output logic [NUM_INT-1:0][NUM_CPU-1:0]   lane_bits,
    output logic [NL*LW-1:0]                  rdata
);
    logic [INT_W-1:0] base;

    // Word accesses start at the aligned group of four interrupts.
    assign base = win_word ? {win_idx[INT_W-1:2], 2'b00} : win_idx;

    // Per-interrupt hit and data lane selection.
    genvar i;
    generate
        for (i = 0; i < NUM_INT; i++) begin : g_lane
            localparam logic [INT_W-1:0] IDX = INT_W'(i);
            assign lane_hit[i]  = win_valid &&
                (win_word ? (IDX[INT_W-1:2] == win_idx[INT_W-1:2]) : (IDX == win_idx));
            assign lane_bits[i] = win_word ? win_wdata[(i % NL)*LW +: NUM_CPU]
                                           : win_wdata[NUM_CPU-1:0];
        end
    endgenerate

    // Read data: one lane for a byte access, four lanes for a word access.
    always_comb begin
        rdata = '0;
        if (win_word) begin
            for (int k = 0; k < NL; k++)
                rdata[k*LW +: NUM_CPU] = rd_masks[base + INT_W'(k)];
        end else begin
            rdata[NUM_CPU-1:0] = rd_masks[base];
        end
    end

    AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_word) |-> (rdata[NL*LW-1:LW] == '0)); // R9
endmodule

// File: rtl/sgi_source_cell.sv
// One (target processor, interrupt) pair: source mask plus pending flag.
// Applies a dispatch first, then a window set or clear on the result.
// Assumes: disp_src is one-hot when disp_hit is set.
module sgi_source_cell #(
    parameter int NUM_CPU = sgi_pkg::SGI_CPUS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_hit,
    input  logic [NUM_CPU-1:0] disp_src,
    input  logic               win_hit,
    input  logic               win_clear,
    input  logic [NUM_CPU-1:0] win_bits,
    output logic [NUM_CPU-1:0] mask,
    output logic               pend
);
    logic [NUM_CPU-1:0] mask_d1, mask_nx;
    logic               pend_d1, pend_nx;

    // Serialised next state: dispatch stage, then window stage.
    always_comb begin
        mask_d1 = disp_hit ? (mask | disp_src) : mask;
        pend_d1 = disp_hit ? 1'b1 : pend;
        mask_nx = mask_d1;
        pend_nx = pend_d1;
        if (win_hit) begin
            if (win_clear) begin
                mask_nx = mask_d1 & ~win_bits;
                if (mask_nx == '0) pend_nx = 1'b0;
            end else begin
                mask_nx = mask_d1 | win_bits;
                if (mask_nx != '0) pend_nx = 1'b1;
            end
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            pend <= 1'b0;
        end else begin
            mask <= mask_nx;
            pend <= pend_nx;
        end
    end

    AST_PEND_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (mask != '0)); // R7
    AST_DISPATCH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_hit && !(win_hit && win_clear)) |=> (pend && ((mask & $past(disp_src)) != '0))); // R5
endmodule

// File: rtl/sgi_dispatch.sv
// Top: software-generated interrupt dispatcher. Decodes dispatch writes into
// per-target source bits, serves the set/clear windows for the accessing
// processor and drives one pending flag per (processor, interrupt).
// Assumes: requester IDs are online; online_cnt in 1..NUM_CPU.
module sgi_dispatch #(
    parameter int NUM_CPU = sgi_pkg::SGI_CPUS,
    parameter int NUM_INT = sgi_pkg::SGI_INTS,
    localparam int CPU_W  = $clog2(NUM_CPU),
    localparam int INT_W  = $clog2(NUM_INT),
    localparam int DW     = sgi_pkg::LANE_W * sgi_pkg::LANES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CPU_W:0]           online_cnt,
    input  logic                     disp_valid,
    input  logic [CPU_W-1:0]         disp_cpu,
    input  logic [DW-1:0]            disp_data,
    input  logic                     win_valid,
    input  logic                     win_write,
    input  logic                     win_clear,
    input  logic                     win_word,
    input  logic [CPU_W-1:0]         win_cpu,
    input  logic [INT_W-1:0]         win_idx,
    input  logic [DW-1:0]            win_wdata,
    output logic [DW-1:0]            win_rdata,
    output logic [NUM_CPU*NUM_INT-1:0] pend_o
);
    sgi_pkg::filt_mode_e                          mode;
    logic [INT_W-1:0]                             disp_int;
    logic [NUM_CPU-1:0]                           targets;
    logic [NUM_CPU-1:0]                           src_onehot;
    logic [NUM_CPU-1:0][NUM_INT-1:0][NUM_CPU-1:0] all_masks;
    logic [NUM_INT-1:0]                           lane_hit;
    logic [NUM_INT-1:0][NUM_CPU-1:0]              lane_bits;

    // Dispatch word field extraction.
    assign mode     = sgi_pkg::filt_mode_e'(disp_data[sgi_pkg::F_MODE_LO +: 2]);
    assign disp_int = disp_data[sgi_pkg::F_INT_LO +: INT_W];

    sgi_target_decode #(.NUM_CPU(NUM_CPU)) i_decode (
        .mode       (mode),
        .list       (disp_data[sgi_pkg::F_LIST_LO +: 8]),
        .req_cpu    (disp_cpu),
        .online_cnt (online_cnt),
        .targets    (targets)
    );

    sgi_window_lanes #(.NUM_CPU(NUM_CPU), .NUM_INT(NUM_INT)) i_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_word  (win_word),
        .win_idx   (win_idx),
        .win_wdata (win_wdata),
        .rd_masks  (all_masks[win_cpu]),
        .lane_hit  (lane_hit),
        .lane_bits (lane_bits),
        .rdata     (win_rdata)
    );

    // Sender bit recorded in every reached mask.
    genvar c, i;
    generate
        for (c = 0; c < NUM_CPU; c++) begin : g_src
            assign src_onehot[c] = (disp_cpu == CPU_W'(c));
        end
    endgenerate

    // Array of cells: one per target processor and interrupt number.
    generate
        for (c = 0; c < NUM_CPU; c++) begin : g_cpu
            for (i = 0; i < NUM_INT; i++) begin : g_int
                logic hit_d, hit_w;
                assign hit_d = disp_valid && targets[c] && (disp_int == INT_W'(i));
                assign hit_w = win_valid && win_write && (win_cpu == CPU_W'(c)) && lane_hit[i];
                sgi_source_cell #(.NUM_CPU(NUM_CPU)) i_cell (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .disp_hit  (hit_d),
                    .disp_src  (src_onehot),
                    .win_hit   (hit_w),
                    .win_clear (win_clear),
                    .win_bits  (lane_bits[i]),
                    .mask      (all_masks[c][i]),
                    .pend      (pend_o[c*NUM_INT + i])
                );
            end

            AST_OTHERS_SKIPS_SELF: assert property (@(posedge clk) disable iff (!rst_n)
                (disp_valid && mode == sgi_pkg::FILT_OTHERS && disp_cpu == CPU_W'(c) && !win_valid)
                |=> $stable(pend_o[c*NUM_INT +: NUM_INT])); // R2
            AST_OFFLINE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
                (disp_valid && !win_valid && (CPU_W+1)'(c) >= online_cnt)
                |=> $stable(pend_o[c*NUM_INT +: NUM_INT])); // R6
        end
    endgenerate

    AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && mode == sgi_pkg::FILT_RSVD && !win_valid) |=> $stable(pend_o)); // R4
endmodule

// File: tb/test_sgi_dispatch.sv
`timescale 1ns/1ps
module test_sgi_dispatch;
    localparam int NC = 8;
    localparam int NI = 16;

    typedef struct packed {
        logic [1:0]  kind;   // 0 dispatch, 1 clear, 2 set, 3 read
        logic [2:0]  cpu;
        logic        word;
        logic [3:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;    // expected read data (reads only)
        logic [3:0]  req;    // requirement number for messages
    } vec_t;

    localparam vec_t VEC [0:16] = '{
        '{2'd0, 3'd1, 1'b0, 4'd5,  32'h000C0005, 32'h0,        4'd1}, // R1 list {2,3}
        '{2'd3, 3'd2, 1'b0, 4'd5,  32'h0,        32'h00000002, 4'd5}, // R5 source bit 1
        '{2'd0, 3'd0, 1'b0, 4'd5,  32'h01000005, 32'h0,        4'd2}, // R2 others
        '{2'd3, 3'd2, 1'b1, 4'd4,  32'h0,        32'h00000300, 4'd9}, // R9 word lane 1
        '{2'd0, 3'd3, 1'b0, 4'd15, 32'h0200000F, 32'h0,        4'd3}, // R3 self
        '{2'd3, 3'd3, 1'b1, 4'd12, 32'h0,        32'h08000000, 4'd3}, // R3 readback
        '{2'd0, 3'd0, 1'b0, 4'd0,  32'h03FF0000, 32'h0,        4'd4}, // R4 reserved
        '{2'd3, 3'd1, 1'b1, 4'd4,  32'h0,        32'h00000100, 4'd2}, // R2 cpu1 reached
        '{2'd0, 3'd2, 1'b0, 4'd3,  32'h00F00003, 32'h0,        4'd6}, // R6 offline only
        '{2'd1, 3'd2, 1'b0, 4'd5,  32'h00000001, 32'h0,        4'd7}, // R7 partial clear
        '{2'd3, 3'd2, 1'b0, 4'd5,  32'h0,        32'h00000002, 4'd7}, // R7 remains
        '{2'd1, 3'd2, 1'b0, 4'd5,  32'h00000002, 32'h0,        4'd7}, // R7 emptied
        '{2'd2, 3'd1, 1'b0, 4'd9,  32'h00000000, 32'h0,        4'd8}, // R8 zero set
        '{2'd2, 3'd1, 1'b1, 4'd8,  32'h00800000, 32'h0,        4'd8}, // R8 word lane 2
        '{2'd3, 3'd1, 1'b1, 4'd8,  32'h0,        32'h00800000, 4'd8}, // R8 readback
        '{2'd1, 3'd3, 1'b1, 4'd4,  32'hFFFFFFFF, 32'h0,        4'd7}, // R7 word clear
        '{2'd3, 3'd3, 1'b0, 4'd5,  32'h0,        32'h00000000, 4'd7}  // R7 readback
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  online_cnt = 4'd4;
    logic        disp_valid = 1'b0;
    logic [2:0]  disp_cpu = '0;
    logic [31:0] disp_data = '0;
    logic        win_valid = 1'b0, win_write = 1'b0, win_clear = 1'b0, win_word = 1'b0;
    logic [2:0]  win_cpu = '0;
    logic [3:0]  win_idx = '0;
    logic [31:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic [NC*NI-1:0] pend_o;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [NC][NI];
    bit done = 0;

    always #4 clk = ~clk;

    sgi_dispatch i_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt),
        .disp_valid(disp_valid), .disp_cpu(disp_cpu), .disp_data(disp_data),
        .win_valid(win_valid), .win_write(win_write), .win_clear(win_clear),
        .win_word(win_word), .win_cpu(win_cpu), .win_idx(win_idx),
        .win_wdata(win_wdata), .win_rdata(win_rdata), .pend_o(pend_o)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NC*NI-1:0] model_pend();
        logic [NC*NI-1:0] v = '0;
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < NI; i++)
                v[c*NI+i] = (model[c][i] != 8'h0);
        return v;
    endfunction

    task automatic model_disp(input logic [2:0] cpu, input logic [31:0] d);
        logic [7:0] tg;
        case (d[25:24])
            2'd0: tg = d[23:16];
            2'd1: tg = 8'hFF & ~(8'h1 << cpu);
            2'd2: tg = 8'h1 << cpu;
            default: tg = 8'h0;
        endcase
        for (int c = 0; c < NC; c++)
            if (tg[c] && c < int'(online_cnt)) model[c][d[3:0]] |= 8'h1 << cpu;
    endtask

    task automatic model_win(input logic clr, input logic [2:0] cpu, input logic word,
                             input logic [3:0] idx, input logic [31:0] d);
        for (int k = 0; k < 4; k++) begin
            if (word || k == 0) begin
                int n = word ? int'({idx[3:2], 2'b00}) + k : int'(idx);
                logic [7:0] b = word ? d[k*8 +: 8] : d[7:0];
                model[cpu][n] = clr ? (model[cpu][n] & ~b) : (model[cpu][n] | b);
            end
        end
    endtask

    task automatic idle();
        disp_valid = 0; win_valid = 0; win_write = 0;
    endtask

    task automatic run_vec(input vec_t v);
        string tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        if (v.kind == 2'd0) begin
            disp_valid = 1; disp_cpu = v.cpu; disp_data = v.data;
        end else begin
            win_valid = 1; win_write = (v.kind != 2'd3); win_clear = (v.kind == 2'd1);
            win_cpu = v.cpu; win_word = v.word; win_idx = v.idx; win_wdata = v.data;
        end
        if (v.kind == 2'd3) begin
            #1 chk({tag, " read"}, 128'(win_rdata), 128'(v.exp));
            idle();
        end else begin
            if (v.kind == 2'd0) model_disp(v.cpu, v.data);
            else model_win(v.kind == 2'd1, v.cpu, v.word, v.idx, v.data);
            @(negedge clk);
            idle();
            chk({tag, " pending"}, pend_o, model_pend());
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) for (int i = 0; i < NI; i++) model[c][i] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset pending", pend_o, '0);
        win_valid = 1; win_word = 1; win_cpu = 0; win_idx = 0;
        #1 chk("R11 reset read", 128'(win_rdata), 128'h0);
        idle();

        foreach (VEC[n]) run_vec(VEC[n]);

        // R10: dispatch and clear in the same cycle; dispatch lands first, clear wins.
        @(negedge clk);
        disp_valid = 1; disp_cpu = 0; disp_data = 32'h00020007;
        win_valid = 1; win_write = 1; win_clear = 1; win_word = 0; win_cpu = 1;
        win_idx = 7; win_wdata = 32'h01;
        model_disp(0, 32'h00020007); model_win(1, 1, 0, 7, 32'h01);
        @(negedge clk); idle();
        chk("R10 dispatch then clear", pend_o, model_pend());
        chk("R10 cpu1 int7 not pending", 128'(pend_o[1*NI+7]), 128'h0);

        // R10: dispatch and set in the same cycle merge.
        disp_valid = 1; disp_cpu = 0; disp_data = 32'h00020008;
        win_valid = 1; win_write = 1; win_clear = 0; win_cpu = 1; win_idx = 8;
        win_wdata = 32'h04;
        model_disp(0, 32'h00020008); model_win(0, 1, 0, 8, 32'h04);
        @(negedge clk); idle();
        chk("R10 dispatch then set pending", pend_o, model_pend());
        win_valid = 1; win_cpu = 1; win_word = 0; win_idx = 8;
        #1 chk("R10 merged mask", 128'(win_rdata), 128'h05);
        idle();

        // R2/R6: eight processors online, others mode from processor 7.
        @(negedge clk);
        online_cnt = 8;
        @(negedge clk);
        disp_valid = 1; disp_cpu = 7; disp_data = 32'h01000001;
        model_disp(7, 32'h01000001);
        @(negedge clk); idle();
        chk("R2 all but requester", pend_o, model_pend());
        chk("R2 requester untouched", 128'(pend_o[7*NI+1]), 128'h0);
        win_valid = 1; win_cpu = 6; win_word = 0; win_idx = 1;
        #1 chk("R5 source is processor 7", 128'(win_rdata), 128'h80);
        idle();

        // R11: reset again clears everything.
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < NC; c++) for (int i = 0; i < NI; i++) model[c][i] = 8'h0;
        chk("R11 reset clears", pend_o, '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule